// File: doc/BRIEF.md
# Privilege-Checked Register Slave

This block is the register front end of a peripheral whose registers are split between two privilege classes. Each of a parameterised number of general data registers is either open to user-mode software or reserved to supervisor mode. A fixed attribute mask, set by parameter, makes that choice. One extra control register holds a global lock bit. While the lock bit is set, every register in the block counts as supervisor-only.

Each request strobe carries an address, a read/write flag, write data and a user-mode flag. The block always answers one cycle later, for either privilege mode. The answer has three parts: an acknowledge pulse, the read data, and an error flag for requests that were refused. A refused request looks the same as an access to an address that does not exist in the block. A refused request never changes any stored value, and it returns zero data.

Top module: `pcr_slave`

## Requirements
- R1: While reset is held, `ack`, `err` and `rdata` are 0. After reset, every data register reads 0 and the control register reads 1, where bit 0 is the lock bit and all other bits are 0.
- R2: A request sampled on a rising edge produces `ack` high for exactly the following cycle. With no request, `ack` stays low. Back-to-back requests give back-to-back acknowledges.
- R3: A supervisor-mode access (`user_mode`=0) to any data register at addresses 0..7 or to the control register at address 8 completes without `err`.
- R4: While the lock bit is 1, every user-mode access gets `ack` with `err`, whatever its address.
- R5: While the lock bit is 0, a user-mode access to a data register whose attribute bit is 0 completes normally. A user-mode access to a register whose attribute bit is 1 gets `err`. The default attribute mask is 8'hF0, which makes registers 4..7 supervisor-only.
- R6: The control register at address 8 is supervisor-only in every state. A supervisor write copies `wdata[0]` into the lock bit.
- R7: Addresses 9..15 are unimplemented. Any access to them, in either mode, gets `ack` with `err`.
- R8: A refused write leaves every data register and the lock bit unchanged.
- R9: `rdata` is 0 on any refused access, on any write, and in any cycle without `ack`.
- R10: `err` is never high without `ack`.
- R11: A permitted read returns the value that the most recent permitted write to that address stored. A write is visible to a read issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request strobe, one per cycle |
| addr | input | 4 | Word address inside the block range |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 16 | Write data |
| user_mode | input | 1 | 1 = user-mode access, 0 = supervisor-mode access |
| ack | output | 1 | Acknowledge, one cycle after `req` |
| rdata | output | 16 | Read data, valid with `ack` |
| err | output | 1 | Bus error, returned together with `ack` |

## Verification
The assertions assume that `addr`, `wr`, `wdata` and `user_mode` are stable and known whenever `req` is high at a rising edge. They also assume that `req` only means something outside reset. The bench changes every input on the falling edge and keeps the address within the 4-bit range, so each sampled request is well defined. The bench holds `req` low until reset is released, and it mixes directed sequences that toggle the lock bit with a pseudo-random phase.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

   // Outcome of decoding one request against the block's address map
   typedef struct packed {
      logic is_data;   // address selects a data register
      logic is_ctrl;   // address selects the control register
      logic fault;     // request must be refused
   } pcr_dec_t;

   // Privilege classes of a request
   typedef enum logic {
      PRIV_SUPER = 1'b0,
      PRIV_USER  = 1'b1
   } pcr_priv_e;

endpackage

// File: rtl/pcr_decode.sv
module pcr_decode
   import pcr_pkg::*;
#(
   parameter int                NUM_REGS  = 8,
   parameter int                ADDR_W    = 4,
   parameter logic [NUM_REGS-1:0] SUPV_MASK = 8'hF0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              user_mode,
   input  logic              lock,
   output pcr_dec_t          dec
);

   localparam int CTRL_ADDR = NUM_REGS;

   logic attr_super;
   pcr_priv_e priv;

   assign priv = pcr_priv_e'(user_mode);

   always_comb begin
      attr_super = 1'b0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (int'(addr) == i) attr_super = SUPV_MASK[i];
      end
   end

   always_comb begin
      dec.is_data = (int'(addr) < NUM_REGS);
      dec.is_ctrl = (int'(addr) == CTRL_ADDR);
      if (!(dec.is_data || dec.is_ctrl)) begin
         dec.fault = 1'b1;                       // unimplemented location
      end else if (priv == PRIV_USER) begin
         dec.fault = lock || dec.is_ctrl || attr_super;
      end else begin
         dec.fault = 1'b0;
      end
   end

   // a refused location never decodes to two targets at once
   always_comb begin
      a_dec_onehot_r7: assert ($onehot0({dec.is_data, dec.is_ctrl}));
   end

endmodule

// File: rtl/pcr_ctrl.sv
module pcr_ctrl #(
   parameter logic LOCK_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wbit,
   output logic lock
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lock <= LOCK_RST;
      else if (wr_en) lock <= wbit;
   end

   p_lock_write_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(lock));

endmodule

// File: rtl/pcr_regfile.sv
module pcr_regfile #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            idx,
   input  logic [DATA_W-1:0]            wdata,
   output logic [DATA_W-1:0]            rd_data,
   output logic [NUM_REGS*DATA_W-1:0]   contents
);

   logic [NUM_REGS-1:0][DATA_W-1:0] regs;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic sel;
      assign sel = wr_en && (int'(idx) == g);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   regs[g] <= '0;
         else if (sel) regs[g] <= wdata;
      end

      assign contents[g*DATA_W +: DATA_W] = regs[g];
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (int'(idx) == i) rd_data = regs[i];
      end
   end

endmodule

// File: rtl/pcr_slave.sv
module pcr_slave
   import pcr_pkg::*;
#(
   parameter int                  NUM_REGS  = 8,
   parameter int                  DATA_W    = 16,
   parameter int                  ADDR_W    = 4,
   parameter logic [NUM_REGS-1:0] SUPV_MASK = 8'hF0,
   parameter logic                LOCK_RST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              user_mode,
   output logic              ack,
   output logic [DATA_W-1:0] rdata,
   output logic              err
);

   localparam int CTRL_ADDR = NUM_REGS;
   localparam int FLAT_W    = NUM_REGS * DATA_W;

   // elaboration-time parameter checks
   if (NUM_REGS < 1) begin : g_chk_regs
      $error("pcr_slave: NUM_REGS must be at least 1");
   end
   if (DATA_W < 2) begin : g_chk_width
      $error("pcr_slave: DATA_W must be at least 2");
   end
   if ((1 << ADDR_W) < NUM_REGS + 1) begin : g_chk_addr
      $error("pcr_slave: ADDR_W too narrow for data and control registers");
   end

   pcr_dec_t            dec;
   logic                lock;
   logic                data_we;
   logic                ctrl_we;
   logic [DATA_W-1:0]   reg_rd;
   logic [DATA_W-1:0]   rd_sel;
   logic [FLAT_W-1:0]   contents;

   pcr_decode #(
      .NUM_REGS  (NUM_REGS),
      .ADDR_W    (ADDR_W),
      .SUPV_MASK (SUPV_MASK)
   ) u_decode (
      .addr      (addr),
      .user_mode (user_mode),
      .lock      (lock),
      .dec       (dec)
   );

   assign data_we = req && wr && dec.is_data && !dec.fault;
   assign ctrl_we = req && wr && dec.is_ctrl && !dec.fault;

   pcr_regfile #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (data_we),
      .idx      (addr),
      .wdata    (wdata),
      .rd_data  (reg_rd),
      .contents (contents)
   );

   pcr_ctrl #(
      .LOCK_RST (LOCK_RST)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (ctrl_we),
      .wbit  (wdata[0]),
      .lock  (lock)
   );

   always_comb begin
      if (dec.is_ctrl) rd_sel = {{(DATA_W-1){1'b0}}, lock};
      else             rd_sel = reg_rd;
   end

   // response stage: one cycle after the strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack   <= 1'b0;
         err   <= 1'b0;
         rdata <= '0;
      end else begin
         ack   <= req;
         err   <= req && dec.fault;
         rdata <= (req && !wr && !dec.fault) ? rd_sel : '0;
      end
   end

   p_ack_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> ack);
   p_ack_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !ack);
   p_err_needs_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ack);
   p_fault_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (rdata == '0));
   p_user_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req && user_mode && lock) |=> err);
   p_ctrl_super_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && user_mode && int'(addr) == CTRL_ADDR) |=> err);
   p_unimpl_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req && int'(addr) > CTRL_ADDR) |=> err);
   p_super_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !user_mode && int'(addr) <= CTRL_ADDR) |=> !err);
   p_fault_write_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req && wr && dec.fault) |=> ($stable(contents) && $stable(lock)));

endmodule

// File: tb/pcr_slave_tb.sv
`timescale 1ns/1ps
module pcr_slave_tb;

   localparam logic [7:0] ATTR = 8'hF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [3:0]  addr = '0;
   logic        wr = 1'b0;
   logic [15:0] wdata = '0;
   logic        user_mode = 1'b0;
   logic        ack;
   logic [15:0] rdata;
   logic        err;

   always #4 clk = ~clk;

   pcr_slave u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .addr      (addr),
      .wr        (wr),
      .wdata     (wdata),
      .user_mode (user_mode),
      .ack       (ack),
      .rdata     (rdata),
      .err       (err)
   );

   // behavioural reference state
   logic [15:0] mreg [8];
   logic        mlock;
   logic        exp_ack;
   logic        exp_err;
   logic [15:0] exp_rdata;
   string       exp_tag;
   int          n_vec;
   int          n_bad;

   task automatic report(string tag, string what, int act, int expv);
      n_vec++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   task automatic compare();
      report(exp_tag, "ack", int'(ack), int'(exp_ack));
      report(exp_tag, "err", int'(err), int'(exp_err));
      report(exp_tag, "rdata", int'(rdata), int'(exp_rdata));
      // R10: an error without an acknowledge is never legal
      report("R10", "err without ack", int'(err && !ack), 0);
   endtask

   // one bus cycle: check the previous answer, then present a new request
   task automatic step(input logic rq, input logic w, input logic [3:0] a,
                       input logic [15:0] d, input logic u, input string tag);
      logic flt;
      @(negedge clk);
      compare();
      req = rq; wr = w; addr = a; wdata = d; user_mode = u;
      flt = (a > 4'd8) || (u && (mlock || a == 4'd8 || (a < 4'd8 && ATTR[a[2:0]])));
      exp_ack   = rq && rst_n;
      exp_err   = rq && rst_n && flt;
      exp_rdata = '0;
      if (rq && rst_n && !w && !flt) exp_rdata = (a == 4'd8) ? {15'b0, mlock} : mreg[a[2:0]];
      if (rq && rst_n && w && !flt) begin
         if (a == 4'd8) mlock = d[0];
         else           mreg[a[2:0]] = d;
      end
      exp_tag = tag;
   endtask

   task automatic idle(input string tag);
      step(1'b0, 1'b0, 4'd0, 16'h0, 1'b0, tag);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] lf;
      n_vec = 0; n_bad = 0;
      for (int i = 0; i < 8; i++) mreg[i] = '0;
      mlock = 1'b1;
      exp_ack = 0; exp_err = 0; exp_rdata = '0; exp_tag = "R1";

      // R1: outputs held low in reset
      repeat (3) idle("R1");
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1");

      // R1: reset contents
      step(1, 0, 4'd8, 0, 0, "R1");
      step(1, 0, 4'd0, 0, 0, "R1");
      step(1, 0, 4'd5, 0, 0, "R1");

      // R3: supervisor writes to every data register, back to back (R2)
      for (int i = 0; i < 8; i++) step(1, 1, 4'(i), 16'hA500 + 16'(i * 17), 0, "R3");
      for (int i = 0; i < 8; i++) step(1, 0, 4'(i), 0, 0, "R11");
      idle("R2");

      // R4: lock set, user accesses refused
      step(1, 0, 4'd0, 0, 1, "R4");
      step(1, 1, 4'd1, 16'hDEAD, 1, "R4");
      step(1, 0, 4'd1, 0, 0, "R8");
      // R6: control register refused to user mode
      step(1, 0, 4'd8, 0, 1, "R6");
      step(1, 1, 4'd8, 16'h0000, 1, "R6");
      step(1, 0, 4'd8, 0, 0, "R8");
      // R6: supervisor clears the lock
      step(1, 1, 4'd8, 16'hFFFE, 0, "R6");
      step(1, 0, 4'd8, 0, 0, "R6");

      // R5: per-register attribute with lock clear
      step(1, 0, 4'd2, 0, 1, "R5");
      step(1, 1, 4'd3, 16'h1234, 1, "R5");
      step(1, 0, 4'd3, 0, 1, "R11");
      step(1, 0, 4'd6, 0, 1, "R9");
      step(1, 1, 4'd7, 16'hBEEF, 1, "R5");
      step(1, 0, 4'd7, 0, 0, "R8");
      step(1, 0, 4'd4, 0, 0, "R3");

      // R7: unimplemented range in both modes
      step(1, 0, 4'd9, 0, 0, "R7");
      step(1, 1, 4'd15, 16'h5555, 0, "R7");
      step(1, 0, 4'd12, 0, 1, "R7");
      step(1, 1, 4'd9, 16'h0001, 1, "R7");
      for (int i = 0; i < 9; i++) step(1, 0, 4'(i), 0, 0, "R8");

      // R9: write responses carry no data
      step(1, 1, 4'd0, 16'h7777, 0, "R9");
      idle("R2");
      idle("R2");

      // R4: lock set again shuts user mode out of open registers
      step(1, 1, 4'd8, 16'h0001, 0, "R6");
      step(1, 0, 4'd2, 0, 1, "R4");
      step(1, 1, 4'd0, 16'h0F0F, 1, "R4");
      step(1, 0, 4'd0, 0, 0, "R8");

      // mixed pseudo-random traffic
      lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(lf[0] | lf[7], lf[1], lf[5:2], {lf[7:0], lf[15:8]}, lf[6], "R11");
      end
      idle("R2");
      idle("R2");
      @(negedge clk);
      compare();
      summary();
      $finish;
   end

endmodule